// File: doc/BRIEF.md
# Flow-Controlled Serial Character Transmitter

This block turns bytes offered on a valid/ready input into asynchronous serial frames on a single output line. A one-cycle baud tick sets the bit period: each bit on the line lasts exactly from one tick to the next. The frame format is chosen by separate mode inputs. These set the number of data bits (five to eight), one or two stop bits, an optional parity bit (even or odd), and an optional ninth bit that marks each character as an address or as data for multidrop buses.

A one-character holding register decouples the input handshake from the line. A new character can be accepted while the previous one is still being shifted out, so characters go out back to back with no idle gap.

When flow control is enabled, the active-low clear-to-send input can pause the stream between characters. The character on the line always completes. If clear-to-send is withdrawn in the second half of that character, one further complete character is also sent. The line then rests at mark until clear-to-send returns, and the held character goes out unchanged.

Top module: `uart_fc_tx`

## Requirements
- R1: After reset, tx is 1, busy is 0 and in_ready is 1.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the parity bit if enabled, then the address/data bit if enabled, then the stop bits at 1. Every bit lasts exactly one baud-tick period, and the line is 1 between frames.
- R3: mode_len selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Input bits above that count are never transmitted.
- R4: mode_two_stop = 0 sends one stop bit; mode_two_stop = 1 sends two.
- R5: With mode_par_en = 1, a parity bit follows the data bits. With mode_par_odd = 0 the data plus parity hold an even number of ones; with mode_par_odd = 1 they hold an odd number.
- R6: mode_mdrop = 01 or 11 adds one bit after the data and parity, equal to in_addr as captured with the character (1 = address). The values 00 and 10 add no bit.
- R7: Mode inputs are sampled when a frame's start bit begins, so a change during a frame affects only later frames.
- R8: With mode_flow_en = 0, cts_n has no effect: characters are sent whenever data is available.
- R9: With mode_flow_en = 1, bits are numbered 0 (start) to N-1 in a frame of N bits. If cts_n is seen high on a tick that ends a bit numbered below N/2 (rounded down), the current frame completes. No further start bit is sent until cts_n is low again, and the held character is then sent unchanged.
- R10: With mode_flow_en = 1, if cts_n is first seen high on a tick that ends a bit numbered N/2 or above, exactly one more complete frame follows the current one before the line rests.
- R11: When a character is held and sending is permitted, its start bit directly follows the last stop bit of the previous frame.
- R12: in_ready is 0 exactly while the holding register is full. busy is 1 while a character is held or a frame is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| mode_len | input | 2 | Data bit count select (5 to 8) |
| mode_two_stop | input | 1 | 1 = two stop bits |
| mode_par_en | input | 1 | 1 = append a parity bit |
| mode_par_odd | input | 1 | 1 = odd parity, 0 = even |
| mode_mdrop | input | 2 | Multidrop select; bit 0 set adds the address/data bit |
| mode_flow_en | input | 1 | 1 = cts_n gates frame starts |
| cts_n | input | 1 | Active-low clear to send |
| in_data | input | DATA_W | Character to send |
| in_addr | input | 1 | Address/data flag for the character |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding register can take a character |
| tx | output | 1 | Serial line, 1 at rest |
| busy | output | 1 | Character held or frame on the line |

## Verification
The hardest situation to reach from the ports is the late withdrawal of clear-to-send. It needs a second character already held, and cts_n has to change within a known bit of the frame in flight. The bench keeps a queue of characters feeding the holding register. A line monitor counts the bits of each frame at every tick. The stimulus waits for the monitor to reach a chosen bit number, then raises cts_n before the next tick, once early in a frame and once past its middle. It then counts the frames that follow and the idle bits on the line.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_SEND = 1'b1
  } line_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       two_stop;
    logic       par_en;
    logic       par_odd;
    logic [1:0] mdrop;
    logic       flow_en;
  } tx_mode_t;

endpackage

// File: rtl/uart_fc_rst_sync.sv
module uart_fc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_ln = s1_q;
endmodule

// File: rtl/uart_fc_frame.sv
module uart_fc_frame
  import uart_fc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 5,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  tx_mode_t              mode,
  input  logic [DATA_W-1:0]     data,
  input  logic                  addr_bit,
  output logic [FRAME_W-1:0]    bits,
  output logic [CNT_W-1:0]      nbits
);
  logic [CNT_W-1:0] dlen;
  logic [CNT_W-1:0] pos;
  logic             par;

  // data count runs from DATA_W-3 to DATA_W
  assign dlen = CNT_W'(DATA_W - 3) + CNT_W'(mode.len_code);

  always_comb begin
    bits    = '1;
    bits[0] = 1'b0;
    pos     = CNT_W'(1);
    par     = mode.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < dlen) begin
        bits[pos] = data[i];
        par       = par ^ data[i];
        pos       = pos + CNT_W'(1);
      end
    end
    if (mode.par_en) begin
      bits[pos] = par;
      pos       = pos + CNT_W'(1);
    end
    if (mode.mdrop[0]) begin
      bits[pos] = addr_bit;
      pos       = pos + CNT_W'(1);
    end
    nbits = pos + (mode.two_stop ? CNT_W'(2) : CNT_W'(1));
  end
endmodule

// File: rtl/uart_fc_shift.sv
module uart_fc_shift
  import uart_fc_pkg::*;
#(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start_ok,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [CNT_W-1:0]   frame_len,
  output logic               tx,
  output logic               active,
  output logic [CNT_W-1:0]   bit_idx,
  output logic [CNT_W-1:0]   len_q,
  output logic               end_tick,
  output logic               start_evt
);
  line_state_e        st_q, st_d;
  logic [CNT_W-1:0]   idx_q, idx_d;
  logic [CNT_W-1:0]   len_r, len_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               tx_q, tx_d;
  logic               last_bit;

  assign last_bit  = (idx_q == len_r - CNT_W'(1));
  assign end_tick  = tick && (st_q == LN_SEND) && last_bit;
  assign start_evt = tick && start_ok && ((st_q == LN_IDLE) || end_tick);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    len_d = len_r;
    sr_d  = sr_q;
    if (start_evt) begin
      st_d  = LN_SEND;
      idx_d = '0;
      len_d = frame_len;
      sr_d  = frame_bits;
    end else if (end_tick) begin
      st_d  = LN_IDLE;
      idx_d = '0;
    end else if (tick && (st_q == LN_SEND)) begin
      idx_d = idx_q + CNT_W'(1);
    end
    tx_d = (st_d == LN_SEND) ? sr_d[idx_d] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      idx_q <= '0;
      len_r <= '0;
      sr_q  <= '1;
      tx_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      len_r <= len_d;
      sr_q  <= sr_d;
      tx_q  <= tx_d;
    end
  end

  assign tx      = tx_q;
  assign active  = (st_q == LN_SEND);
  assign bit_idx = idx_q;
  assign len_q   = len_r;
endmodule

// File: rtl/uart_fc_gate.sv
module uart_fc_gate #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic [CNT_W-1:0] len_q,
  input  logic             end_tick,
  input  logic             start_evt,
  input  logic             cts_n,
  input  logic             flow_en,
  output logic             permit,
  output logic             carry_q
);
  logic             early_q, early_d;
  logic             late_q, late_d;
  logic             carry_d;
  logic [CNT_W-1:0] half;
  logic             sample, early_now, late_now, early_any, late_any, carry_eff;

  assign half      = len_q >> 1;
  assign sample    = tick && active;
  assign early_now = sample && cts_n && (bit_idx < half);
  assign late_now  = sample && cts_n && (bit_idx >= half);
  assign early_any = early_q || early_now;
  assign late_any  = late_q || late_now;
  assign carry_eff = end_tick ? (late_any && !early_any) : carry_q;
  assign permit    = !flow_en || !cts_n || carry_eff;

  always_comb begin
    early_d = early_q;
    late_d  = late_q;
    carry_d = carry_q;
    if (start_evt) begin
      early_d = 1'b0;
      late_d  = 1'b0;
      carry_d = 1'b0;
    end else if (end_tick) begin
      early_d = 1'b0;
      late_d  = 1'b0;
      carry_d = carry_eff;
    end else if (sample) begin
      early_d = early_any;
      late_d  = late_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
      late_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      early_q <= early_d;
      late_q  <= late_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        mode_len,
  input  logic              mode_two_stop,
  input  logic              mode_par_en,
  input  logic              mode_par_odd,
  input  logic [1:0]        mode_mdrop,
  input  logic              mode_flow_en,
  input  logic              cts_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_addr,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               rst_ln;
  tx_mode_t           mode;
  logic               hold_valid_q, hold_valid_d;
  logic [DATA_W-1:0]  hold_data_q, hold_data_d;
  logic               hold_addr_q, hold_addr_d;
  logic               accept;
  logic [FRAME_W-1:0] frame_bits;
  logic [CNT_W-1:0]   frame_len;
  logic               permit, carry_q;
  logic               line_active, end_tick, start_evt;
  logic [CNT_W-1:0]   bit_idx, len_q;

  uart_fc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ln (rst_ln)
  );

  assign mode = '{len_code: mode_len, two_stop: mode_two_stop, par_en: mode_par_en,
                  par_odd: mode_par_odd, mdrop: mode_mdrop, flow_en: mode_flow_en};

  assign in_ready = !hold_valid_q;
  assign accept   = in_valid && in_ready;

  always_comb begin
    hold_valid_d = hold_valid_q;
    hold_data_d  = hold_data_q;
    hold_addr_d  = hold_addr_q;
    if (accept) begin
      hold_valid_d = 1'b1;
      hold_data_d  = in_data;
      hold_addr_d  = in_addr;
    end else if (start_evt) begin
      hold_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
      hold_addr_q  <= 1'b0;
    end else begin
      hold_valid_q <= hold_valid_d;
      hold_data_q  <= hold_data_d;
      hold_addr_q  <= hold_addr_d;
    end
  end

  uart_fc_frame #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_frame (
    .mode     (mode),
    .data     (hold_data_q),
    .addr_bit (hold_addr_q),
    .bits     (frame_bits),
    .nbits    (frame_len)
  );

  uart_fc_shift #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_ln),
    .tick       (baud_tick),
    .start_ok   (hold_valid_q && permit),
    .frame_bits (frame_bits),
    .frame_len  (frame_len),
    .tx         (tx),
    .active     (line_active),
    .bit_idx    (bit_idx),
    .len_q      (len_q),
    .end_tick   (end_tick),
    .start_evt  (start_evt)
  );

  uart_fc_gate #(
    .CNT_W (CNT_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_ln),
    .tick      (baud_tick),
    .active    (line_active),
    .bit_idx   (bit_idx),
    .len_q     (len_q),
    .end_tick  (end_tick),
    .start_evt (start_evt),
    .cts_n     (cts_n),
    .flow_en   (mode_flow_en),
    .permit    (permit),
    .carry_q   (carry_q)
  );

  assign busy = hold_valid_q || line_active;
endmodule

// File: rtl/uart_fc_tx_chk.sv
module uart_fc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx,
  input logic busy,
  input logic in_valid,
  input logic in_ready,
  input logic cts_n,
  input logic mode_flow_en,
  input logic line_active,
  input logic carry_q
);
  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |-> tx);

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(baud_tick) |-> $stable(tx));

  // R12
  accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  // R12
  busy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> busy);

  // R9
  rest_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && !$past(line_active) && $past(mode_flow_en) && $past(cts_n))
      |-> $past(carry_q));
endmodule

bind uart_fc_tx uart_fc_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_ln),
  .baud_tick    (baud_tick),
  .tx           (tx),
  .busy         (busy),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .cts_n        (cts_n),
  .mode_flow_en (mode_flow_en),
  .line_active  (line_active),
  .carry_q      (carry_q)
);

// File: tb/sim_uart_fc_tx.sv
module sim_uart_fc_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic [1:0] mode_len;
  logic       mode_two_stop, mode_par_en, mode_par_odd, mode_flow_en;
  logic [1:0] mode_mdrop;
  logic       cts_n;
  logic [7:0] in_data;
  logic       in_addr, in_valid;
  logic       in_ready, tx, busy;

  uart_fc_tx u0 (
    .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick),
    .mode_len (mode_len), .mode_two_stop (mode_two_stop), .mode_par_en (mode_par_en),
    .mode_par_odd (mode_par_odd), .mode_mdrop (mode_mdrop), .mode_flow_en (mode_flow_en),
    .cts_n (cts_n), .in_data (in_data), .in_addr (in_addr), .in_valid (in_valid),
    .in_ready (in_ready), .tx (tx), .busy (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int div_cnt = 0;
  always @(posedge clk) begin
    div_cnt   <= (div_cnt == DIV-1) ? 0 : div_cnt + 1;
    baud_tick <= (div_cnt == DIV-1);
  end

  logic [8:0]  send_q[$];
  logic [15:0] exp_bits_q[$];
  int          exp_len_q[$];

  int total = 0, bad = 0;
  int mon_chk = 0, mon_bad = 0;
  int wd_bad = 0;

  function automatic void build(input logic [1:0] lc, input logic ts, input logic pe,
                                input logic po, input logic [1:0] md, input logic [7:0] d,
                                input logic a, output logic [15:0] b, output int n);
    logic p;
    b = '1; b[0] = 1'b0; n = 1; p = po;
    for (int i = 0; i < 5 + int'(lc); i++) begin
      b[n] = d[i]; p = p ^ d[i]; n++;
    end
    if (pe) begin b[n] = p; n++; end
    if (md[0]) begin b[n] = a; n++; end
    n = n + (ts ? 2 : 1);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] lc, input logic ts, input logic pe,
                         input logic po, input logic [1:0] md, input logic fl);
    mode_len = lc; mode_two_stop = ts; mode_par_en = pe;
    mode_par_odd = po; mode_mdrop = md; mode_flow_en = fl;
  endtask

  task automatic push(input logic [7:0] d, input logic a);
    logic [15:0] b; int n;
    build(mode_len, mode_two_stop, mode_par_en, mode_par_odd, mode_mdrop, d, a, b, n);
    exp_bits_q.push_back(b);
    exp_len_q.push_back(n);
    send_q.push_back({a, d});
  endtask

  // driver
  initial begin
    in_valid = 1'b0; in_data = '0; in_addr = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && send_q.size() > 0 && in_ready) begin
        {in_addr, in_data} = send_q.pop_front();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
  end

  // line monitor: one sample per tick, value of the bit that is ending
  logic        mon_in = 1'b0;
  int          mon_pos = 0, mon_n = 0, mon_started = 0, mon_done = 0;
  int          mon_idle = 0, mon_gap_total = 0;
  logic [15:0] mon_bits, mon_exp;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && baud_tick === 1'b1) begin
      if (!mon_in) begin
        if (tx == 1'b0) begin
          mon_started++;
          mon_gap_total += mon_idle;
          mon_idle = 0;
          mon_bits = '1; mon_bits[0] = 1'b0;
          mon_pos = 1;
          if (exp_len_q.size() == 0) begin
            mon_chk++; mon_bad++;
            $display("FAIL R2 unexpected start bit actual=1 expected=0");
          end else begin
            mon_in  = 1'b1;
            mon_n   = exp_len_q.pop_front();
            mon_exp = exp_bits_q.pop_front();
          end
        end else begin
          mon_idle++;
        end
      end else begin
        mon_bits[mon_pos] = tx;
        mon_pos++;
        if (mon_pos == mon_n) begin
          mon_in = 1'b0;
          mon_done++;
          mon_chk++;
          // R2 R3 R4 R5 R6 frame content
          if (mon_bits != mon_exp) begin
            mon_bad++;
            $display("FAIL R2 R3 R4 R5 R6 frame actual=%h expected=%h", mon_bits, mon_exp);
          end
        end
      end
    end
  end

  task automatic drain();
    do @(posedge clk);
    while (send_q.size() > 0 || exp_len_q.size() > 0 || mon_in || busy);
    repeat (3 * DIV) @(posedge clk);
  endtask

  task automatic wait_pos(input int start_no, input int k);
    do @(posedge clk);
    while (!(mon_started == start_no && mon_in && mon_pos == k));
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total + mon_chk + wd_bad, bad + mon_bad + wd_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    int d0, s0, b0, g0;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; cts_n = 1'b0;
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(tx == 1'b1, "R1 tx", tx, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // R3 upper bits dropped with 5 data bits
    d0 = mon_done;
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    push(8'hFF, 1'b0); push(8'hE0, 1'b0);
    drain();
    chk(mon_done == d0 + 2, "R3 short frames", mon_done - d0, 2);

    // random formats
    for (int g = 0; g < 6; g++) begin
      set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
      cts_n = 1'b0;
      for (int k = 0; k < 12; k++) push(8'($urandom), 1'($urandom));
      drain();
    end

    // R8 cts ignored when flow is off; R11 gapless back to back
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    cts_n = 1'b1;
    d0 = mon_done; s0 = mon_started;
    push(8'hA5, 1'b0); push(8'h3C, 1'b0); push(8'h0F, 1'b0);
    do @(posedge clk); while (mon_started != s0 + 1);
    g0 = mon_gap_total;
    drain();
    chk(mon_done == d0 + 3, "R8 frames sent", mon_done - d0, 3);
    chk(mon_gap_total == g0, "R11 idle bits between frames", mon_gap_total - g0, 0);

    // R9 early withdrawal
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    cts_n = 1'b0;
    d0 = mon_done; s0 = mon_started;
    push(8'h11, 1'b0); push(8'h22, 1'b0); push(8'h33, 1'b0);
    wait_pos(s0 + 1, 1);
    cts_n = 1'b1;
    repeat (40 * DIV) @(negedge clk);
    chk(mon_done == d0 + 1, "R9 frames before pause", mon_done - d0, 1);
    chk(mon_idle >= 25 && !mon_in, "R9 idle line", mon_idle, 25);
    chk(busy == 1'b1, "R12 busy while held", busy, 1);
    chk(in_ready == 1'b0, "R12 ready low while held", in_ready, 0);
    cts_n = 1'b0;
    drain();
    chk(mon_done == d0 + 3, "R9 resume without loss", mon_done - d0, 3);

    // R10 late withdrawal
    d0 = mon_done; s0 = mon_started;
    push(8'h44, 1'b1); push(8'h55, 1'b0); push(8'h66, 1'b0);
    wait_pos(s0 + 1, 6);
    cts_n = 1'b1;
    repeat (60 * DIV) @(negedge clk);
    chk(mon_done == d0 + 2, "R10 one extra frame", mon_done - d0, 2);
    chk(mon_idle >= 20 && !mon_in, "R10 idle line", mon_idle, 20);
    cts_n = 1'b0;
    drain();
    chk(mon_done == d0 + 3, "R10 resume", mon_done - d0, 3);

    // R7 mode change inside a frame
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    d0 = mon_done; s0 = mon_started; b0 = mon_bad;
    push(8'hC3, 1'b0);
    wait_pos(s0 + 1, 3);
    set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0);
    push(8'h96, 1'b1);
    drain();
    chk(mon_done == d0 + 2, "R7 frames", mon_done - d0, 2);
    chk(mon_bad == b0, "R7 frames keep their own format", mon_bad - b0, 0);

    // R6 reserved multidrop code adds no bit
    set_cfg(2'b10, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);
    d0 = mon_done;
    push(8'h7E, 1'b1);
    drain();
    chk(mon_done == d0 + 1, "R6 reserved code frame", mon_done - d0, 1);

    finish_up();
  end
endmodule